// File: doc/BRIEF.md
# Serial Register Access Port with Fault-Status Header

This block is a serial slave that lets a host reach a bank of 16-bit registers through fixed-length 24-bit transfers framed by an active-low chip select. The host sends a frame-type bit, an operation bit, a 6-bit address and 16 data bits. While the frame is coming in, the slave returns a status byte followed by the addressed register's contents. The status byte condenses a set of fault and warning flags into single bits. A write returns the register's old value and commits the new value only when the frame closes with exactly 24 clocks.

The serial pins are brought into the system clock domain through two-flop synchronizers and sampled there, so the system clock must run several times faster than the serial clock. The serial clock idles low, input data is captured on its falling edge and output data is updated on its rising edge. A sticky error bit reports any frame that closed with a clock count other than 24. The host clears that bit through a control register.

Top module: `spi_regfile_slave`

## Requirements
- R1: An input frame has 24 bits, most significant bit first: bit 23 is the frame type (0 = standard), bit 22 is the operation (0 = write, 1 = read), bits 21..16 are the address and bits 15..0 are the data. The slave captures input bits on falling serial-clock edges and updates its output bit on rising serial-clock edges.
- R2: Response bits 23..16, latched when chip select falls, are 1, 1, FAULT, WARN, OV_UV, DRV, OTSD, ERR, in that order from bit 23 down.
- R3: FAULT is the OR of every fault_in bit, ov_flag, uv_flag, every drv_flt bit and otsd_flag. WARN is the OR of the warn_in bits. OV_UV is ov_flag OR uv_flag. DRV is the OR of the drv_flt bits. OTSD follows otsd_flag.
- R4: On a read, response bits 15..0 are the register's current contents, and the input data bits have no effect on any register.
- R5: On a write, response bits 15..0 are the register's contents before the write. The new value is stored when chip select rises.
- R6: A register is written only when chip select rises after exactly 24 serial clocks, with bit 23 equal to 0 and bit 22 equal to 0. Frames that are shorter or longer, and frames with bit 23 equal to 1, leave every register unchanged.
- R7: ERR is set when chip select rises after a clock count other than 24, and it stays set. A valid write to address 47 with data bit 0 equal to 1 clears it. Bit 0 of register 47 always reads 0.
- R8: All registers reset to zero. Addresses 48 to 63 are not implemented: they read as zero and ignore writes.
- R9: The output drive enable is high while the synchronized chip select is low and low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Drive enable for the serial output pad |
| fault_in | input | NFLT | Generic fault flags |
| warn_in | input | NWARN | Warning flags |
| drv_flt | input | NDRV | Driver fault flags |
| ov_flag | input | 1 | Supply overvoltage flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| otsd_flag | input | 1 | Overtemperature shutdown flag |

## Verification
On every cycle, the assertions check that the bit counter restarts when a frame opens, that the output bit changes only on a rising serial-clock edge or at frame start, and that the first output bit is 1. They also check that ERR rises only at a frame close with a bad count and falls only at a valid clear write, and that register 0 changes only when a frame closes. The bench scenarios alone show the values of the status bits, the old-versus-current data in the response, and the rejection of short, long and non-standard frames. They also cover the unimplemented addresses and the masking of the clear bit, all checked against a behavioural register model in the bench.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int NREGS    = 48,
  parameter int CLR_ADDR = 47,
  parameter int NFLT     = 4,
  parameter int NWARN    = 3,
  parameter int NDRV     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_csn,
  input  logic             spi_sdi,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  input  logic [NFLT-1:0]  fault_in,
  input  logic [NWARN-1:0] warn_in,
  input  logic [NDRV-1:0]  drv_flt,
  input  logic             ov_flag,
  input  logic             uv_flag,
  input  logic             otsd_flag
);
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int FW = 24;
  localparam logic [AW-1:0] FRAME_BITS = AW'(FW);
  localparam logic [AW-1:0] HDR_BITS   = AW'(8);

  logic [2:0] sck_s, cs_s;
  logic [1:0] sdi_s;
  logic [AW-1:0] bit_cnt;
  logic [FW-1:0] rx, tx;
  logic sdo_q, spi_err;
  logic [DW-1:0] regs [NREGS];

  wire cs_act     = ~cs_s[1];
  wire cs_fall    = cs_s[2] & ~cs_s[1];
  wire cs_rise    = ~cs_s[2] & cs_s[1];
  wire sclk_rise  = cs_act & ~sck_s[2] & sck_s[1];
  wire sclk_fall  = cs_act & sck_s[2] & ~sck_s[1];
  wire sdi_bit    = sdi_s[1];

  wire [7:0] status = {2'b11,
                       (|fault_in) | ov_flag | uv_flag | (|drv_flt) | otsd_flag,
                       |warn_in, ov_flag | uv_flag, |drv_flt, otsd_flag, spi_err};

  wire [AW-1:0] rd_addr = {rx[4:0], sdi_bit};
  wire [DW-1:0] rd_val  = (int'(rd_addr) < NREGS) ? regs[rd_addr] : '0;

  wire [AW-1:0] fr_addr = rx[21:16];
  wire len_ok  = (bit_cnt == FRAME_BITS);
  wire wr_ok   = len_ok & ~rx[23] & ~rx[22] & (int'(fr_addr) < NREGS);
  wire clr_hit = wr_ok & (int'(fr_addr) == CLR_ADDR) & rx[0];

  assign spi_sdo    = sdo_q;
  assign spi_sdo_oe = cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], spi_sclk};
      cs_s  <= {cs_s[1:0], spi_csn};
      sdi_s <= {sdi_s[0], spi_sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      sdo_q   <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      tx      <= {status, {DW{1'b0}}};
      sdo_q   <= status[7];
    end else begin
      if (sclk_rise) begin
        sdo_q <= tx[FW-1];
        tx    <= {tx[FW-2:0], 1'b0};
      end
      if (sclk_fall) begin
        rx <= {rx[FW-2:0], sdi_bit};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == HDR_BITS - 1'b1) tx[FW-1:FW-DW] <= rd_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_err <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (cs_rise) begin
      if (!len_ok) spi_err <= 1'b1;
      else if (clr_hit) spi_err <= 1'b0;
      if (wr_ok)
        regs[fr_addr] <= (int'(fr_addr) == CLR_ADDR) ? {rx[DW-1:1], 1'b0} : rx[DW-1:0];
    end
  end

  // R1
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> bit_cnt == '0);

  // R1
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !cs_fall) |=> $stable(spi_sdo));

  // R2
  lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> spi_sdo);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_err) |-> $past(cs_rise && bit_cnt != FRAME_BITS));

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_err) |-> $past(cs_rise && clr_hit));

  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(regs[0]));
endmodule

// File: tb/sim_spi_regfile_slave.sv
module sim_spi_regfile_slave;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, csn = 1, sdi = 0;
  logic sdo, sdo_oe;
  logic [3:0] fault_in = 0;
  logic [2:0] warn_in = 0;
  logic [5:0] drv_flt = 0;
  logic ov = 0, uv = 0, otsd = 0;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [64];
  bit err_m = 0;

  always #10 clk = ~clk;

  spi_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .fault_in(fault_in), .warn_in(warn_in),
    .drv_flt(drv_flt), .ov_flag(ov), .uv_flag(uv), .otsd_flag(otsd));

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic f;
    f = (|fault_in) | ov | uv | (|drv_flt) | otsd;
    return {2'b11, f, |warn_in, ov | uv, |drv_flt, otsd, err_m};
  endfunction

  task automatic xfer(input logic [23:0] din, input int nbits, input string tag);
    logic [23:0] dout = 0;
    logic [23:0] exp;
    logic [5:0] a = din[21:16];
    exp = {exp_status(), (a < 48) ? model[a] : 16'h0};
    @(negedge clk); csn = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1;
      sdi = (i < 24) ? din[23 - i] : 1'b0;
      repeat (6) @(negedge clk);
      if (i == 0) chk(sdo_oe === 1'b1, "R9 oe during frame", {23'b0, sdo_oe}, 24'h1);
      if (i < 24) dout[23 - i] = sdo;
      sclk = 0;
      repeat (6) @(negedge clk);
    end
    csn = 1;
    repeat (8) @(negedge clk);
    chk(sdo_oe === 1'b0, "R9 oe idle", {23'b0, sdo_oe}, 24'h0);
    if (nbits >= 24) chk(dout === exp, tag, dout, exp);
    if (nbits != 24) err_m = 1;
    else if (!din[23] && !din[22] && a < 48) begin
      model[a] = (a == 47) ? {din[15:1], 1'b0} : din[15:0];
      if (a == 47 && din[0]) err_m = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(sdo_oe === 1'b0, "R9 reset oe", {23'b0, sdo_oe}, 24'h0);
    xfer({2'b01, 6'd0, 16'h0}, 24, "R8 reset read 0");
    xfer({2'b01, 6'd47, 16'h0}, 24, "R8 reset read 47");
    xfer({2'b00, 6'd5, 16'hA5A5}, 24, "R5 write returns old");
    xfer({2'b00, 6'd5, 16'h1234}, 24, "R5 write returns previous");
    xfer({2'b01, 6'd5, 16'hFFFF}, 24, "R4 read current");
    xfer({2'b01, 6'd5, 16'h0000}, 24, "R4 read data ignored");
    xfer({2'b00, 6'd0, 16'h8001}, 24, "R1 write addr 0");
    xfer({2'b01, 6'd0, 16'h0}, 24, "R1 read addr 0");
    fault_in = 4'b0100;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R3 fault only");
    fault_in = 0; warn_in = 3'b010;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R3 warn only");
    warn_in = 0; uv = 1;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R2 uv sets fault and ov_uv");
    uv = 0; drv_flt = 6'b100000;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R3 drv");
    drv_flt = 0; otsd = 1;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R3 otsd");
    otsd = 0; ov = 1; warn_in = 3'b001;
    xfer({2'b01, 6'd5, 16'h0}, 24, "R2 ov and warn");
    ov = 0; warn_in = 0;
    xfer({2'b00, 6'd6, 16'hBEEF}, 16, "R6 short frame");
    xfer({2'b01, 6'd6, 16'h0}, 24, "R7 err set after short frame");
    xfer({2'b01, 6'd6, 16'h0}, 24, "R7 err sticky");
    xfer({2'b00, 6'd7, 16'hCAFE}, 30, "R6 long frame response");
    xfer({2'b01, 6'd7, 16'h0}, 24, "R6 long frame no write");
    xfer({2'b10, 6'd8, 16'h5555}, 24, "R6 nonstandard frame");
    xfer({2'b01, 6'd8, 16'h0}, 24, "R6 nonstandard no write");
    xfer({2'b00, 6'd47, 16'h0003}, 24, "R7 clear write");
    xfer({2'b01, 6'd47, 16'h0}, 24, "R7 err cleared bit0 masked");
    xfer({2'b00, 6'd50, 16'h7777}, 24, "R8 unimplemented write");
    xfer({2'b01, 6'd50, 16'h0}, 24, "R8 unimplemented reads zero");
    xfer({2'b01, 6'd5, 16'h0}, 24, "R4 final read");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule